// File: doc/BRIEF.md
# Programmable Down-Counting Timer/Counter Channel

This block is one channel of a four-channel counter/timer peripheral. The CPU programs it over a byte-wide bus. A control byte sets the mode. An optional time-constant byte may follow the control byte, and a separate byte holds the interrupt vector. Once started, the channel counts down from the time constant. On reaching zero it reloads the constant by itself and keeps running, with no further CPU action.

The channel has two clock sources:

- **Timer mode.** The count steps on a prescaler that divides the system clock by 16 or by 256. The channel can also be told to wait for an edge on its trigger input before it starts.
- **Counter mode.** The count steps once per active edge on the trigger input. The edge is first synchronised to the system clock.

Each zero count produces a one-clock pulse on the zero-count output. Channels can be chained by feeding one channel's pulse into the next channel's trigger. The last channel of the group has no such output. A zero count can also raise an interrupt request, which stays high until the CPU reads the channel. The CPU can read the remaining count at any time.

Top module: `cnt_tmr_chan`

## Requirements
- R1: After reset the read data is 0, the zero-count pulse is low, the interrupt request is low and the stored vector is 0. The channel is then stopped.
- R2: The channel tells bytes apart as follows.
  - A written byte with bit 0 = 1 is a control byte. Its bits mean: 7 interrupt enable, 6 counter mode, 5 divide by 256, 4 rising active edge, 3 timer waits for trigger, 2 time constant follows, 1 software stop.
  - A byte with bit 0 = 0 is stored on `vec_byte`, with bit 0 forced to 0.
  - The byte written right after a control byte that has bit 2 set is always taken as the time constant, whatever its bit 0.
- R3: A time-constant byte N loads the count with N, or with 256 when N is 0. The read data shows the low 8 bits of the count, so 256 reads as 0. While running, the count stays within 1..256.
- R4: In timer mode (bit 6 = 0) the count drops by one every 16 system clocks when bit 5 = 0, or every 256 when bit 5 = 1. The first step comes that many clocks after the time constant is written.
- R5: In counter mode (bit 6 = 1) each active trigger edge lowers the count by one. The active edge is the rising edge when bit 4 = 1 and the falling edge when bit 4 = 0. The opposite edge has no effect.
- R6: A step taken at count 1 reloads the stored time constant and counting continues. Each reload gives exactly one `zero_pulse` high for a single clock.
- R7: In timer mode with bit 3 = 1, the count holds after the time constant is written. Timing starts at the first active trigger edge.
- R8: A control byte with bit 2 = 0 never starts the channel. A control byte with bit 1 or bit 2 set stops counting, and the count then holds its value.
- R9: With bit 7 = 1, every zero count sets `irq_req`. It then stays high until a selected read strobe or reset. With bit 7 = 0, a zero count leaves it low.
- R10: A write counts only when `bus_cs` = 1 and `bus_ch` equals the channel's number. Any other write changes nothing.
- R11: The highest-numbered channel (CH_ID = NUM_CH-1) keeps `zero_pulse` at 0 at all times. Its counting and interrupt still work.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_cs | input | 1 | Peripheral chip select |
| bus_ch | input | SEL_W | Channel number addressed by the CPU |
| bus_wr | input | 1 | Write strobe, one clock per byte |
| bus_rd | input | 1 | Read strobe, clears a pending interrupt |
| bus_wdata | input | 8 | Write data byte |
| bus_rdata | output | 8 | Remaining count, low 8 bits |
| trig_in | input | 1 | Asynchronous trigger / count input |
| zero_pulse | output | 1 | One-clock pulse per zero count |
| irq_req | output | 1 | Interrupt request |
| vec_byte | output | 8 | Stored interrupt vector byte |

## Verification
The assertions assume several things about the inputs:

- Reset is held low for at least one clock before any bus activity.
- Write and read strobes last one clock per byte.
- The trigger input stays at each level for at least one clock, so synchronised edges never fall on adjacent cycles.

The bench keeps to this. Every bus access lasts exactly one clock between falling edges. Every trigger level is held for three or more clocks. Checks are taken only after the two-stage synchroniser and the edge register have settled, so the pulse-width and reload properties are never tested on input that breaks these assumptions.

// File: rtl/cnt_tmr_pkg.sv
package cnt_tmr_pkg;

  localparam int TC_W  = 8;
  localparam int CNT_W = TC_W + 1;

  typedef struct packed {
    logic irq_en;
    logic cnt_mode;
    logic pre_big;
    logic rise;
    logic trg_start;
  } mode_t;

  // A time-constant byte of zero stands for the full 2**TC_W range.
  function automatic logic [CNT_W-1:0] tc_expand(input logic [TC_W-1:0] b);
    if (b == '0) return CNT_W'(1) << TC_W;
    return {1'b0, b};
  endfunction

  // Number of system clocks per prescaler tick.
  function automatic int unsigned prescale_span(input logic big,
                                                input int unsigned small_log,
                                                input int unsigned big_log);
    return big ? (32'd1 << big_log) : (32'd1 << small_log);
  endfunction

endpackage

// File: rtl/cnt_tmr_bus.sv
module cnt_tmr_bus
  import cnt_tmr_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_hit,
  input  logic [TC_W-1:0]     wdata,
  output mode_t               mode,
  output logic [TC_W-1:0]     tc_byte,
  output logic [TC_W-1:0]     vec_q,
  output logic                load,
  output logic [CNT_W-1:0]    load_val,
  output logic                halt
);

  logic awaiting_tc;
  logic is_ctrl;

  assign is_ctrl  = wdata[0];
  assign load     = wr_hit && awaiting_tc;
  assign load_val = tc_expand(wdata);
  assign halt     = wr_hit && !awaiting_tc && is_ctrl && (wdata[1] || wdata[2]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode        <= '0;
      tc_byte     <= '0;
      vec_q       <= '0;
      awaiting_tc <= 1'b0;
    end else if (wr_hit) begin
      if (awaiting_tc) begin
        tc_byte     <= wdata;
        awaiting_tc <= 1'b0;
      end else if (is_ctrl) begin
        mode        <= mode_t'(wdata[7:3]);
        awaiting_tc <= wdata[2];
      end else begin
        vec_q       <= {wdata[TC_W-1:1], 1'b0};
      end
    end
  end

  AST_IGNORE_UNSEL: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_hit |=> ($stable(mode) && $stable(vec_q) && $stable(tc_byte))); // R10

  AST_VEC_EVEN: assert property (@(posedge clk) disable iff (!rst_n)
    vec_q[0] == 1'b0); // R2

endmodule

// File: rtl/cnt_tmr_sync.sv
module cnt_tmr_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic trig_in,
  input  logic rise,
  output logic edge_evt
);

  logic [SYNC_STAGES-1:0] sh;
  logic                   level;
  logic                   prev;

  assign level = sh[SYNC_STAGES-1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh   <= '0;
      prev <= 1'b0;
    end else begin
      sh   <= {sh[SYNC_STAGES-2:0], trig_in};
      prev <= level;
    end
  end

  assign edge_evt = rise ? (level && !prev) : (!level && prev);

  AST_EDGE_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
    edge_evt |=> !edge_evt); // R5

endmodule

// File: rtl/cnt_tmr_prescale.sv
module cnt_tmr_prescale
  import cnt_tmr_pkg::*;
#(
  parameter int PRE_SMALL_LOG = 4,
  parameter int PRE_BIG_LOG   = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic clear,
  input  logic big,
  output logic tick
);

  localparam int PW = PRE_BIG_LOG;

  logic [PW-1:0] pre;
  int unsigned   span;

  assign span = prescale_span(big, PRE_SMALL_LOG, PRE_BIG_LOG);
  assign tick = run && ((32'(pre) + 32'd1) == span);

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      pre <= '0;
    end else if (run) begin
      pre <= tick ? '0 : pre + PW'(1);
    end
  end

  AST_PRE_IN_SPAN: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (32'(pre) < span)); // R4

endmodule

// File: rtl/cnt_tmr_down.sv
module cnt_tmr_down
  import cnt_tmr_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic [CNT_W-1:0]   load_val,
  input  logic               halt,
  input  logic [TC_W-1:0]    tc_byte,
  input  mode_t              mode,
  input  logic               edge_evt,
  input  logic               tick,
  input  logic               rd_clr,
  output logic [CNT_W-1:0]   cnt,
  output logic               running,
  output logic               zc_evt,
  output logic               irq
);

  logic armed;
  logic dec;
  logic start_evt;

  assign dec       = running && !load && !halt && (mode.cnt_mode ? edge_evt : tick);
  assign zc_evt    = dec && (cnt == CNT_W'(1));
  assign start_evt = armed && !load && !halt && !mode.cnt_mode && edge_evt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt     <= '0;
      running <= 1'b0;
      armed   <= 1'b0;
    end else if (load) begin
      cnt <= load_val;
      if (mode.cnt_mode || !mode.trg_start) begin
        running <= 1'b1;
        armed   <= 1'b0;
      end else begin
        running <= 1'b0;
        armed   <= 1'b1;
      end
    end else if (halt) begin
      running <= 1'b0;
      armed   <= 1'b0;
    end else begin
      if (start_evt) begin
        running <= 1'b1;
        armed   <= 1'b0;
      end
      if (dec) begin
        cnt <= zc_evt ? tc_expand(tc_byte) : cnt - CNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq <= 1'b0;
    end else if (zc_evt && mode.irq_en) begin
      irq <= 1'b1;
    end else if (rd_clr) begin
      irq <= 1'b0;
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    running |-> (cnt != '0 && cnt <= (CNT_W'(1) << TC_W))); // R3

  AST_RELOAD_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
    zc_evt |=> (cnt == tc_expand(tc_byte))); // R6

  AST_STOPPED_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (!running && !load) |=> $stable(cnt)); // R8

  AST_TICK_TIMER_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    tick |-> !mode.cnt_mode); // R4

  AST_ARMED_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && !edge_evt && !load) |=> $stable(cnt)); // R7

  AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !rd_clr) |=> irq); // R9

  AST_IRQ_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(mode.irq_en)); // R9

endmodule

// File: rtl/cnt_tmr_chan.sv
module cnt_tmr_chan
  import cnt_tmr_pkg::*;
#(
  parameter int NUM_CH        = 4,
  parameter int CH_ID         = 0,
  parameter int PRE_SMALL_LOG = 4,
  parameter int PRE_BIG_LOG   = 8,
  parameter int SYNC_STAGES   = 2,
  localparam int SEL_W        = $clog2(NUM_CH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_cs,
  input  logic [SEL_W-1:0] bus_ch,
  input  logic             bus_wr,
  input  logic             bus_rd,
  input  logic [7:0]       bus_wdata,
  output logic [7:0]       bus_rdata,
  input  logic             trig_in,
  output logic             zero_pulse,
  output logic             irq_req,
  output logic [7:0]       vec_byte
);

  localparam bit HAS_ZC = (CH_ID != NUM_CH - 1);

  logic             sel;
  logic             wr_hit;
  logic             rd_hit;
  mode_t            mode;
  logic [TC_W-1:0]  tc_byte;
  logic             load;
  logic [CNT_W-1:0] load_val;
  logic             halt;
  logic             edge_evt;
  logic             tick;
  logic [CNT_W-1:0] cnt;
  logic             running;
  logic             zc_evt;

  assign sel    = bus_cs && (bus_ch == SEL_W'(CH_ID));
  assign wr_hit = sel && bus_wr;
  assign rd_hit = sel && bus_rd;

  cnt_tmr_bus u_bus (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_hit   (wr_hit),
    .wdata    (bus_wdata),
    .mode     (mode),
    .tc_byte  (tc_byte),
    .vec_q    (vec_byte),
    .load     (load),
    .load_val (load_val),
    .halt     (halt)
  );

  cnt_tmr_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .trig_in  (trig_in),
    .rise     (mode.rise),
    .edge_evt (edge_evt)
  );

  cnt_tmr_prescale #(
    .PRE_SMALL_LOG (PRE_SMALL_LOG),
    .PRE_BIG_LOG   (PRE_BIG_LOG)
  ) u_pre (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (running && !mode.cnt_mode),
    .clear (load || halt),
    .big   (mode.pre_big),
    .tick  (tick)
  );

  cnt_tmr_down u_down (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (load),
    .load_val (load_val),
    .halt     (halt),
    .tc_byte  (tc_byte),
    .mode     (mode),
    .edge_evt (edge_evt),
    .tick     (tick),
    .rd_clr   (rd_hit),
    .cnt      (cnt),
    .running  (running),
    .zc_evt   (zc_evt),
    .irq      (irq_req)
  );

  assign bus_rdata = cnt[7:0];

  generate
    if (HAS_ZC) begin : g_zc
      logic zc_q;
      always_ff @(posedge clk) begin
        if (!rst_n) zc_q <= 1'b0;
        else        zc_q <= zc_evt;
      end
      assign zero_pulse = zc_q;

      AST_ZC_ONE_WIDE: assert property (@(posedge clk) disable iff (!rst_n)
        zero_pulse |=> !zero_pulse); // R6

      AST_ZC_AFTER_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(zero_pulse) |-> $past(running)); // R6
    end else begin : g_no_zc
      assign zero_pulse = 1'b0;
    end
  endgenerate

endmodule

// File: tb/cnt_tmr_chan_test.sv
`timescale 1ns/1ps
module cnt_tmr_chan_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_cs = 1'b0;
  logic [1:0] bus_ch = 2'd0;
  logic       bus_wr = 1'b0;
  logic       bus_rd = 1'b0;
  logic [7:0] bus_wdata = 8'd0;
  logic       trig_in = 1'b0;
  logic [7:0] rdata, rdata_l, vec, vec_l;
  logic       zp, zp_l, irq, irq_l;

  always #4 clk = ~clk;

  cnt_tmr_chan #(.CH_ID(0)) uut (
    .clk(clk), .rst_n(rst_n), .bus_cs(bus_cs), .bus_ch(bus_ch),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata),
    .bus_rdata(rdata), .trig_in(trig_in), .zero_pulse(zp),
    .irq_req(irq), .vec_byte(vec));

  cnt_tmr_chan #(.CH_ID(3)) uut_last (
    .clk(clk), .rst_n(rst_n), .bus_cs(bus_cs), .bus_ch(bus_ch),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata),
    .bus_rdata(rdata_l), .trig_in(trig_in), .zero_pulse(zp_l),
    .irq_req(irq_l), .vec_byte(vec_l));

  int checks = 0;
  int errors = 0;
  int zc_total = 0;
  int zc_last_total = 0;
  int zc_wide = 0;
  logic zp_prev = 1'b0;
  bit timed_out = 1'b0;

  always @(negedge clk) begin
    if (zp) zc_total++;
    if (zp_l) zc_last_total++;
    if (zp && zp_prev) zc_wide++;
    zp_prev <= zp;
  end

  task automatic chk(input int act, input int exp, input string tag);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_byte(input logic [1:0] ch, input logic [7:0] b,
                         input logic cs_v = 1'b1);
    @(negedge clk);
    bus_cs = cs_v; bus_ch = ch; bus_wdata = b; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; bus_cs = 1'b0;
  endtask

  task automatic rd_pulse(input logic [1:0] ch);
    @(negedge clk);
    bus_cs = 1'b1; bus_ch = ch; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0; bus_cs = 1'b0;
  endtask

  task automatic trig_pulse();
    @(negedge clk);
    trig_in = 1'b1;
    wait_n(3);
    trig_in = 1'b0;
    wait_n(3);
  endtask

  task automatic run_tests();
    int base;
    // R1 reset state
    chk(rdata, 0, "R1 count");
    chk(zp, 0, "R1 zero pulse");
    chk(irq, 0, "R1 irq");
    chk(vec, 0, "R1 vector");

    // R8 control byte without time constant leaves channel stopped
    base = zc_total;
    wr_byte(0, 8'h01);
    wait_n(100);
    chk(rdata, 0, "R8 no start count");
    chk(zc_total - base, 0, "R8 no start pulses");

    // R4 R6 timer sweep, divide by 16: value after k steps is tc - k mod tc
    for (int tc = 1; tc <= 6; tc++) begin
      wr_byte(0, 8'h05);
      wr_byte(0, 8'(tc));
      base = zc_total;
      chk(rdata, tc, "R3 loaded value");
      wait_n(8);
      for (int k = 0; k < 8; k++) begin
        chk(rdata, tc - (k % tc), "R4 timer/16 count");
        chk(zc_total - base, k / tc, "R6 timer reload pulses");
        wait_n(16);
      end
    end

    // R4 divide by 256
    wr_byte(0, 8'h25);
    wr_byte(0, 8'd2);
    base = zc_total;
    wait_n(356);
    chk(rdata, 1, "R4 timer/256 first step");
    wait_n(256);
    chk(rdata, 2, "R6 timer/256 reload");
    chk(zc_total - base, 1, "R6 timer/256 pulse");

    // R5 R6 counter sweep, rising edges
    for (int tc = 1; tc <= 5; tc++) begin
      wr_byte(0, 8'h55);
      wr_byte(0, 8'(tc));
      base = zc_total;
      for (int p = 1; p <= 8; p++) begin
        trig_pulse();
        chk(rdata, tc - (p % tc), "R5 counter count");
        chk(zc_total - base, p / tc, "R6 counter pulses");
      end
    end

    // R5 only the rising edge counts when bit 4 = 1
    wr_byte(0, 8'h55);
    wr_byte(0, 8'd10);
    @(negedge clk) trig_in = 1'b1;
    wait_n(5);
    chk(rdata, 9, "R5 rising edge counted");
    trig_in = 1'b0;
    wait_n(5);
    chk(rdata, 9, "R5 falling edge ignored");

    // R5 only the falling edge counts when bit 4 = 0
    wr_byte(0, 8'h45);
    wr_byte(0, 8'd10);
    @(negedge clk) trig_in = 1'b1;
    wait_n(5);
    chk(rdata, 10, "R5 rising edge ignored");
    trig_in = 1'b0;
    wait_n(5);
    chk(rdata, 9, "R5 falling edge counted");

    // R3 zero byte means 256
    wr_byte(0, 8'h55);
    wr_byte(0, 8'h00);
    chk(rdata, 0, "R3 256 reads as 0");
    trig_pulse();
    chk(rdata, 255, "R3 step from 256");

    // R7 timer waits for trigger
    wr_byte(0, 8'h1D);
    wr_byte(0, 8'd4);
    wait_n(100);
    chk(rdata, 4, "R7 held before trigger");
    @(negedge clk) trig_in = 1'b1;
    wait_n(40);
    chk(rdata, 2, "R7 running after trigger");
    trig_in = 1'b0;

    // R8 software stop freezes the count
    wr_byte(0, 8'h05);
    wr_byte(0, 8'd200);
    wait_n(40);
    chk(rdata, 198, "R8 before stop");
    base = zc_total;
    wr_byte(0, 8'h03);
    wait_n(100);
    chk(rdata, 198, "R8 frozen after stop");
    chk(zc_total - base, 0, "R8 no pulses when stopped");

    // R9 interrupt set at zero, held, cleared by read
    wr_byte(0, 8'hD5);
    wr_byte(0, 8'd1);
    chk(irq, 0, "R9 irq idle");
    trig_pulse();
    chk(irq, 1, "R9 irq raised");
    wait_n(20);
    chk(irq, 1, "R9 irq held");
    rd_pulse(0);
    chk(irq, 0, "R9 irq cleared by read");
    wr_byte(0, 8'h55);
    wr_byte(0, 8'd1);
    base = zc_total;
    trig_pulse();
    chk(zc_total - base, 1, "R9 zero reached with irq off");
    chk(irq, 0, "R9 irq stays low when disabled");

    // R2 vector storage and byte steering
    wr_byte(0, 8'hA6);
    chk(vec, 8'hA6, "R2 vector stored");
    wr_byte(0, 8'h55);
    wr_byte(0, 8'h20);
    chk(rdata, 32, "R2 even byte taken as time constant");
    chk(vec, 8'hA6, "R2 vector untouched by time constant");

    // R10 unselected writes are ignored
    wr_byte(1, 8'h10);
    chk(vec, 8'hA6, "R10 other channel");
    wr_byte(0, 8'h22, 1'b0);
    chk(vec, 8'hA6, "R10 chip select low");
    wr_byte(0, 8'h55);
    wr_byte(2, 8'h30);
    chk(rdata, 32, "R10 constant to other channel ignored");
    wr_byte(0, 8'h07);
    chk(rdata, 7, "R10 constant still expected");

    // R11 last channel: no zero pulse, interrupt still works
    wr_byte(3, 8'hD5);
    wr_byte(3, 8'd1);
    trig_pulse();
    chk(irq_l, 1, "R11 last channel reached zero");
    chk(zc_last_total, 0, "R11 last channel pulse absent");
    chk(rdata_l, 1, "R11 last channel reloaded");

    chk(zc_wide, 0, "R6 zero pulse one clock wide");
  endtask

  initial begin
    wait_n(4);
    rst_n = 1'b1;
    fork
      run_tests();
      begin
        repeat (200000) @(posedge clk);
        timed_out = 1'b1;
      end
    join_any
    disable fork;
    if (timed_out) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual 1 expected 0");
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule